// File: doc/BRIEF.md
# Floating-Point Maximum with Selectable NaN Combining

This unit returns the larger of two IEEE binary64 operands, `op_a_i` and `op_b_i`. Operands arrive with a valid strobe. The result and an invalid-operation flag are registered and appear one cycle later. Ordinary values are ordered by a quiet less-than. That compare places -0 and +0 at the same value and raises nothing on quiet NaNs. When exactly one operand is a NaN, the other operand is returned as it is.

When both operands are NaNs, a 1-bit policy input chooses how the two are merged into one quiet NaN. The first policy favours operand A. The second policy prefers an operand that was already quiet, and otherwise picks the payload with the larger magnitude. It has a fixed tie-break. The policy is sampled in the same cycle as the operands. The exponent and fraction widths are parameters, so the same logic can be built for narrow formats.

Top module: `fp_max_unit`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous clock edge. While `rst_ni` is low, `valid_o` and `invalid_o` read 0.
- R2: When neither operand is a NaN, the result is the operand with the greater numeric value. If the values are equal, including +0 against -0, the result is operand B.
- R3: When exactly one operand is a NaN, the result is the other operand, bit for bit.
- R4: `invalid_o` is 1 exactly when either operand is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and a 0 in the top fraction bit.
- R5: When both operands are NaNs, the result is a NaN with the top fraction bit set. All other bits come from the chosen operand.
- R6: When `policy_i` = 0 and both operands are NaNs, the result is operand A with its top fraction bit forced to 1.
- R7: When `policy_i` = 1 and both operands are NaNs, with exactly one of them signaling, the result is the quiet one.
- R8: When `policy_i` = 1 and both operands are NaNs, either both signaling or both quiet, each operand is first quieted. The result is the quieted operand whose bits below the sign are larger as an unsigned number. If those bits are equal, the quieted operand with the smaller full unsigned pattern wins, which is the positive one.
- R9: A cycle with `valid_i` = 0 leaves `result_o` and `invalid_o` unchanged.
- R10: `policy_i` takes effect only for the operands presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| policy_i | input | 1 | NaN merge policy: 0 favours A, 1 uses quiet-then-magnitude |
| op_a_i | input | EXP_W+FRAC_W+1 | Operand A (operand 1) |
| op_b_i | input | EXP_W+FRAC_W+1 | Operand B (operand 2) |
| valid_o | output | 1 | Result strobe |
| result_o | output | EXP_W+FRAC_W+1 | Maximum |
| invalid_o | output | 1 | Signaling-NaN input seen |

## Verification
The hardest case to reach is the magnitude policy's tie-break. It needs two NaNs whose payloads match after quieting but whose signs differ, and also the mixes in which quieting alone makes two different payloads equal. Random 64-bit operands almost never hit either pattern. The bench therefore builds the unit with a 3-bit exponent and a 3-bit fraction and applies every ordered operand pair under both policies. Each outcome is checked against a model that orders values numerically.

// File: rtl/fpmax_pkg.sv
package fpmax_pkg;
  typedef enum logic {
    NAN_FIRST  = 1'b0,
    NAN_LARGER = 1'b1
  } nan_pol_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic mag_zero;
  } fp_kind_t;
endpackage

// File: rtl/fp_kind.sv
module fp_kind
  import fpmax_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output fp_kind_t              kind_o
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;

  assign exp_f    = op_i[W-2 -: EXP_W];
  assign frac_f   = op_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;

  always_comb begin
    kind_o          = '0;
    kind_o.sign     = op_i[W-1];
    kind_o.is_nan   = exp_ones && (|frac_f);
    kind_o.is_snan  = kind_o.is_nan && !frac_f[FRAC_W-1];
    kind_o.mag_zero = ~|op_i[W-2:0];
  end
endmodule

// File: rtl/fp_quiet_lt.sv
module fp_quiet_lt
  import fpmax_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  fp_kind_t     kx_i,
  input  fp_kind_t     ky_i,
  output logic         lt_o
);
  logic ucmp_lt;
  logic pat_eq;

  assign ucmp_lt = x_i < y_i;
  assign pat_eq  = x_i == y_i;

  always_comb begin
    if (kx_i.is_nan || ky_i.is_nan) begin
      lt_o = 1'b0;
    end else if (kx_i.sign != ky_i.sign) begin
      // opposite signs: x below y only if x negative and not both zero
      lt_o = kx_i.sign && !(kx_i.mag_zero && ky_i.mag_zero);
    end else begin
      lt_o = !pat_eq && (kx_i.sign ^ ucmp_lt);
    end
  end
endmodule

// File: rtl/fp_nan_pick.sv
module fp_nan_pick
  import fpmax_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  nan_pol_e              policy_i,
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  fp_kind_t              ka_i,
  input  fp_kind_t              kb_i,
  output logic [EXP_W+FRAC_W:0] nan_o
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] qa, qb;
  logic [W-1:0] first_pick, larger_pick, mixed_pick;

  assign qa = a_i | QBIT;
  assign qb = b_i | QBIT;

  assign first_pick = (ka_i.is_snan || ka_i.is_nan) ? qa : qb;

  // exactly one signaling: prefer the other when it is a NaN
  always_comb begin
    if (ka_i.is_snan) mixed_pick = kb_i.is_nan ? qb : qa;
    else              mixed_pick = ka_i.is_nan ? qa : qb;
  end

  always_comb begin
    if (qa[W-2:0] > qb[W-2:0])      larger_pick = qa;
    else if (qb[W-2:0] > qa[W-2:0]) larger_pick = qb;
    else                            larger_pick = (qa < qb) ? qa : qb;
  end

  always_comb begin
    unique case (policy_i)
      NAN_FIRST:  nan_o = first_pick;
      NAN_LARGER: nan_o = (ka_i.is_snan ^ kb_i.is_snan) ? mixed_pick : larger_pick;
      default:    nan_o = first_pick;
    endcase
  end
endmodule

// File: rtl/fp_max_unit.sv
module fp_max_unit
  import fpmax_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  policy_i,
  input  logic [EXP_W+FRAC_W:0] op_a_i,
  input  logic [EXP_W+FRAC_W:0] op_b_i,
  output logic                  valid_o,
  output logic [EXP_W+FRAC_W:0] result_o,
  output logic                  invalid_o
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  fp_kind_t     kind_a, kind_b;
  logic         b_lt_a;
  logic [W-1:0] nan_res;
  logic [W-1:0] res_d;
  logic         inv_d;
  nan_pol_e     pol;

  assign pol = nan_pol_e'(policy_i);

  fp_kind #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_kind_a (.op_i(op_a_i), .kind_o(kind_a));
  fp_kind #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_kind_b (.op_i(op_b_i), .kind_o(kind_b));

  fp_quiet_lt #(.W(W)) u_lt (
    .x_i (op_b_i),
    .y_i (op_a_i),
    .kx_i(kind_b),
    .ky_i(kind_a),
    .lt_o(b_lt_a)
  );

  fp_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pick (
    .policy_i(pol),
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .ka_i    (kind_a),
    .kb_i    (kind_b),
    .nan_o   (nan_res)
  );

  always_comb begin
    if (kind_a.is_nan && kind_b.is_nan) res_d = nan_res;
    else if (kind_b.is_nan || b_lt_a)   res_d = op_a_i;
    else                                res_d = op_b_i;
  end

  assign inv_d = kind_a.is_snan || kind_b.is_snan;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        invalid_o <= inv_d;
      end
    end
  end
endmodule

// File: rtl/fp_max_unit_chk.sv
module fp_max_unit_chk #(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  policy_i,
  input logic [EXP_W+FRAC_W:0] op_a_i,
  input logic [EXP_W+FRAC_W:0] op_b_i,
  input logic                  valid_o,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  invalid_o
);
  localparam int unsigned W = EXP_W + FRAC_W + 1;

  function automatic logic nan_f(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
  endfunction

  function automatic logic snan_f(input logic [W-1:0] v);
    return nan_f(v) && !v[FRAC_W-1];
  endfunction

  logic a_nan, b_nan, any_snan;
  assign a_nan    = nan_f(op_a_i);
  assign b_nan    = nan_f(op_b_i);
  assign any_snan = snan_f(op_a_i) || snan_f(op_b_i);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!valid_o && !invalid_o);
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_one_nan_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_nan && !b_nan) |=> result_o == $past(op_b_i));

  p_snan_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && any_snan) |=> invalid_o);

  p_no_snan_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !any_snan) |=> !invalid_o);

  p_nan_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_nan && b_nan) |=> (nan_f(result_o) && result_o[FRAC_W-1]));

  p_first_nan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_nan && b_nan && !policy_i) |=>
      result_o[W-1:FRAC_W] == $past(op_a_i[W-1:FRAC_W]) &&
      result_o[FRAC_W-2:0] == $past(op_a_i[FRAC_W-2:0]));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(invalid_o)));
endmodule

bind fp_max_unit fp_max_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .policy_i (policy_i),
  .op_a_i   (op_a_i),
  .op_b_i   (op_b_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .invalid_o(invalid_o)
);

// File: tb/fp_max_unit_tb_top.sv
`timescale 1ns/1ps
module fp_max_unit_tb_top;
  localparam int EW = 3;
  localparam int FW = 3;
  localparam int W  = EW + FW + 1;
  localparam int N  = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         policy_i = 1'b0;
  logic [W-1:0] op_a_i = '0;
  logic [W-1:0] op_b_i = '0;
  logic         valid_o;
  logic [W-1:0] result_o;
  logic         invalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  fp_max_unit #(.EXP_W(EW), .FRAC_W(FW)) dut_i (
    .clk_i, .rst_ni, .valid_i, .policy_i, .op_a_i, .op_b_i,
    .valid_o, .result_o, .invalid_o
  );

  function automatic bit is_nan(input logic [W-1:0] v);
    return (v[5:3] == 3'b111) && (v[2:0] != 3'b000);
  endfunction
  function automatic bit is_snan(input logic [W-1:0] v);
    return is_nan(v) && !v[2];
  endfunction
  function automatic int value_of(input logic [W-1:0] v);
    int m;
    m = int'(v[5:0]);
    return v[6] ? -m : m;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input bit pol, output string req);
    logic [W-1:0] qa, qb;
    qa = a | 7'b000_0100;
    qb = b | 7'b000_0100;
    if (is_nan(a) && is_nan(b)) begin
      if (!pol) begin req = "R6"; return qa; end
      if (is_snan(a) != is_snan(b)) begin req = "R7"; return is_snan(a) ? qb : qa; end
      req = "R8";
      if (qa[5:0] > qb[5:0]) return qa;
      if (qb[5:0] > qa[5:0]) return qb;
      return (qa < qb) ? qa : qb;
    end
    if (is_nan(a)) begin req = "R3"; return b; end
    if (is_nan(b)) begin req = "R3"; return a; end
    req = "R2";
    return (value_of(a) > value_of(b)) ? a : b;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  initial begin
    logic [W-1:0] exp_r;
    logic [W-1:0] held_r;
    logic         held_f;
    string        req;
    repeat (3) @(negedge clk_i);
    chk("R1", {6'd0, valid_o}, 7'd0);
    chk("R1", {6'd0, invalid_o}, 7'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {6'd0, valid_o}, 7'd0);
    // full sweep, both policies (R10: policy changes along with operands)
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          policy_i = p[0];
          op_a_i   = a[W-1:0];
          op_b_i   = b[W-1:0];
          valid_i  = 1'b1;
          exp_r    = model(a[W-1:0], b[W-1:0], p[0], req);
          @(negedge clk_i);
          chk(req, result_o, exp_r);
          chk("R4", {6'd0, invalid_o},
              {6'd0, is_snan(a[W-1:0]) || is_snan(b[W-1:0])});
          chk("R1", {6'd0, valid_o}, 7'd1);
          if (is_nan(a[W-1:0]) && is_nan(b[W-1:0])) chk("R5", {6'd0, result_o[2]}, 7'd1);
        end
      end
    end
    // R9: idle cycles hold result and flag; R10: policy alone does nothing
    op_a_i = 7'b0111001; op_b_i = 7'b1111001; policy_i = 1'b1;
    @(negedge clk_i);
    held_r = result_o; held_f = invalid_o;
    valid_i = 1'b0;
    op_a_i = 7'b0000001; op_b_i = 7'b0000010; policy_i = 1'b0;
    @(negedge clk_i);
    chk("R1", {6'd0, valid_o}, 7'd0);
    chk("R9", result_o, held_r);
    chk("R9", {6'd0, invalid_o}, {6'd0, held_f});
    policy_i = 1'b1;
    @(negedge clk_i);
    chk("R10", result_o, held_r);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule